// File: doc/BRIEF.md
# Interleaved Ring-Position Decoder

This block turns a snapshot of a one-hot ring counter into the binary index of the counter's position. Real counter snapshots can carry a stray bit next to the leading one, so the decoder accepts one such bubble. A word that fits no recognised shape maps to zero. The block accepts one word per clock, and its output also changes once per clock.

The decode is copied into several identical lanes, two by default. A free-running phase counter gives each lane its clock enable in turn. On the cycle a lane is enabled, it captures the incoming word and also loads the result it decoded from its previous word. Between those two loads the decode logic of a lane has a full lane-count of clock periods to settle. The phase counter also drives an output multiplexer. That multiplexer always shows the lane that loaded on the most recent clock edge. The valid strobe goes through a matching register pipeline, so it arrives together with its data. The data path is not gated by the strobe.

Top module: `ring_pos_decoder`

## Requirements
- R1: For each k from 0 to WORD_W-1, a word whose only set bit is bit WORD_W-1-k decodes to k. For the 8-bit default, bit 7 alone gives 0 and bit 1 alone gives 6.
- R2: The bit directly below the set bit is ignored. For example, 8'hC0 decodes to 0 and 8'h06 decodes to 5.
- R3: The ignored neighbour wraps around the ring. Bit 0 set together with bit 7 decodes to WORD_W-1, and so does bit 0 alone (8'h81 and 8'h01 both give 7).
- R4: Any word that fits none of the WORD_W shapes decodes to 0. This includes 8'h00, 8'hFF and 8'h41.
- R5: With the default of two lanes, a word present at clock edge t shows on pos_out between edge t+2 and edge t+3. Consecutive words come out in consecutive cycles with no gaps.
- R6: pos_vld is word_vld delayed by the same latency as the data. The data path decodes words whether word_vld is set or not.
- R7: While rst is high at a clock edge, pos_out, pos_vld, the phase counter and every lane register are cleared to zero.
- R8: The phase counter advances by one modulo LANES every cycle, and exactly one lane is enabled in each cycle. A lane's result register holds its value in every cycle when that lane is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | Marks word_in as meaningful |
| word_in | input | WORD_W | Ring-counter snapshot |
| pos_vld | output | 1 | Delayed copy of word_vld, aligned with pos_out |
| pos_out | output | $clog2(WORD_W) | Decoded ring position |

## Verification
The assertions assume that rst is held high for at least one edge before any checked traffic. They also assume word_in is a defined value at every edge, because each lane captures whatever is on the port when its turn comes, including words marked not valid. The stimulus holds reset for several cycles and drives a defined word in every cycle, even where the valid strobe is low. It covers a full back-to-back sweep of all 256 words and then random words, about half of which are deliberately shaped to match a pattern, with a random valid strobe.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

   // True when v is a positive power of two.
   function automatic bit rpd_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // Index of the ring neighbour just below idx, wrapping at bit 0.
   function automatic int rpd_below(input int idx, input int w);
      return (idx + w - 1) % w;
   endfunction

endpackage

// File: rtl/rpd_match.sv
module rpd_match
   import rpd_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int POS_W  = 3
) (
   input  logic [WORD_W-1:0] word,
   output logic [POS_W-1:0]  pos
);

   logic [WORD_W-1:0] hit;

   // One comparator per ring position: the required bit set, the
   // neighbour below it masked out, and all other bits clear.
   generate
      for (genvar k = 0; k < WORD_W; k++) begin : g_shape
         localparam int REQ = WORD_W - 1 - k;
         localparam int NB  = rpd_below(REQ, WORD_W);
         localparam logic [WORD_W-1:0] MUST = WORD_W'(1) << REQ;
         localparam logic [WORD_W-1:0] CARE = ~(WORD_W'(1) << NB);
         assign hit[k] = ((word & CARE) == MUST);
      end
   endgenerate

   // The shape nearest the MSB wins. Later assignments override
   // earlier ones, so the loop runs from the LSB end upward.
   always_comb begin
      pos = '0;
      for (int k = WORD_W - 1; k >= 0; k--) begin
         if (hit[k]) pos = POS_W'(k);
      end
   end

endmodule

// File: rtl/rpd_phase.sv
module rpd_phase
   import rpd_pkg::*;
#(
   parameter int LANES = 2,
   parameter int PH_W  = 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [PH_W-1:0]  phase,
   output logic [LANES-1:0] lane_en
);

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= phase_q + PH_W'(1);
   end

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_en
         assign lane_en[i] = (phase_q == PH_W'(i));
      end
   endgenerate

   assign phase = phase_q;

   // R8: exactly one lane is enabled per cycle
   a_r8_one_lane: assert property (@(posedge clk) disable iff (rst)
      $onehot(lane_en));

   // R8: the phase steps by one every cycle
   a_r8_phase_step: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> phase_q == PH_W'($past(phase_q) + PH_W'(1)));

   // R7: reset returns the phase to zero
   a_r7_phase_reset: assert property (@(posedge clk)
      $past(rst) |-> phase_q == '0);

endmodule

// File: rtl/rpd_lane.sv
module rpd_lane
   import rpd_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int POS_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [WORD_W-1:0] word_in,
   output logic [POS_W-1:0]  pos_q
);

   logic [WORD_W-1:0] cap_q;
   logic [POS_W-1:0]  pos_d;
   logic [POS_W-1:0]  pos_r;

   // The captured word stays put for a whole lane period, which
   // gives the decoder the full window to settle.
   always_ff @(posedge clk) begin
      if (rst)     cap_q <= '0;
      else if (en) cap_q <= word_in;
   end

   rpd_match #(.WORD_W(WORD_W), .POS_W(POS_W)) u_match (
      .word (cap_q),
      .pos  (pos_d)
   );

   always_ff @(posedge clk) begin
      if (rst)     pos_r <= '0;
      else if (en) pos_r <= pos_d;
   end

   assign pos_q = pos_r;

   // R8: an idle lane holds its result
   a_r8_lane_hold: assert property (@(posedge clk) disable iff (rst)
      (!en && !$past(rst)) |=> $stable(pos_r));

   // R4: an all-zero capture produces a zero result
   a_r4_zero_word: assert property (@(posedge clk) disable iff (rst)
      (en && cap_q == '0) |=> pos_r == '0);

   // R7: reset clears both lane registers
   a_r7_lane_reset: assert property (@(posedge clk)
      $past(rst) |-> (pos_r == '0 && cap_q == '0));

endmodule

// File: rtl/ring_pos_decoder.sv
module ring_pos_decoder
   import rpd_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int LANES  = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       word_vld,
   input  logic [WORD_W-1:0]          word_in,
   output logic                       pos_vld,
   output logic [$clog2(WORD_W)-1:0]  pos_out
);

   localparam int POS_W = $clog2(WORD_W);
   localparam int PH_W  = (LANES > 2) ? $clog2(LANES) : 1;
   localparam int VLD_D = LANES + 1;

   // Elaboration-time parameter checks
   generate
      if (WORD_W < 3 || !rpd_is_pow2(WORD_W)) begin : g_bad_width
         $error("ring_pos_decoder: WORD_W must be a power of two, at least 4");
      end
      if (LANES < 2 || !rpd_is_pow2(LANES)) begin : g_bad_lanes
         $error("ring_pos_decoder: LANES must be a power of two, at least 2");
      end
   endgenerate

   logic [PH_W-1:0]  phase;
   logic [LANES-1:0] lane_en;
   logic [POS_W-1:0] lane_pos [LANES];
   logic [PH_W-1:0]  sel;
   logic [VLD_D-1:0] vpipe_q;

   rpd_phase #(.LANES(LANES), .PH_W(PH_W)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .phase   (phase),
      .lane_en (lane_en)
   );

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         rpd_lane #(.WORD_W(WORD_W), .POS_W(POS_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .en      (lane_en[i]),
            .word_in (word_in),
            .pos_q   (lane_pos[i])
         );
      end
   endgenerate

   // Phase has already moved on, so the lane that loaded on the last
   // edge is the one just behind it.
   assign sel     = phase - PH_W'(1);
   assign pos_out = lane_pos[sel];

   // Valid: one capture stage plus one stage per lane period.
   always_ff @(posedge clk) begin
      if (rst) vpipe_q <= '0;
      else     vpipe_q <= {vpipe_q[VLD_D-2:0], word_vld};
   end

   assign pos_vld = vpipe_q[VLD_D-1];

   // Edges since reset, saturating; gates the history checks below.
   logic [1:0] seen_q;
   always_ff @(posedge clk) begin
      if (rst)              seen_q <= '0;
      else if (seen_q != 3) seen_q <= seen_q + 2'd1;
   end

   generate
      if (LANES == 2) begin : g_chk2
         // R6: valid follows the input strobe three edges later
         a_r6_vld_delay: assert property (@(posedge clk) disable iff (rst)
            (seen_q == 3) |-> pos_vld == $past(word_vld, 3));

         // R5: a zero word shows as position zero at the fixed latency
         a_r5_zero_latency: assert property (@(posedge clk) disable iff (rst)
            (seen_q == 3 && $past(word_in, 3) == '0) |-> pos_out == '0);
      end
   endgenerate

   // R7: outputs are clear right after reset
   a_r7_out_reset: assert property (@(posedge clk)
      $past(rst) |-> (pos_out == '0 && !pos_vld));

endmodule

// File: tb/sim_ring_pos_decoder.sv
module sim_ring_pos_decoder;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       word_vld = 1'b0;
   logic [7:0] word_in = '0;
   logic       pos_vld;
   logic [2:0] pos_out;

   int n_chk = 0;
   int n_bad = 0;
   int n_idx = 0;
   logic [7:0] hw [0:1023];
   logic       hv [0:1023];

   always #2.5 clk = ~clk;  // 200 MHz

   ring_pos_decoder u0 (
      .clk      (clk),
      .rst      (rst),
      .word_vld (word_vld),
      .word_in  (word_in),
      .pos_vld  (pos_vld),
      .pos_out  (pos_out)
   );

   // Reference: shape k needs bit 7-k set, ignores the bit below it
   // (wrapping), needs every other bit clear. Unmatched words give 0.
   function automatic logic [2:0] ref_pos(input logic [7:0] w);
      for (int k = 0; k < 8; k++) begin
         int r  = 7 - k;
         int nb = (r == 0) ? 7 : r - 1;
         logic [7:0] rest = w;
         rest[r]  = 1'b0;
         rest[nb] = 1'b0;
         if (w[r] && rest == 8'h00) return 3'(k);
      end
      return 3'd0;
   endfunction

   function automatic string req_of(input logic [7:0] w);
      if (ref_pos(w) == 3'd0 && w[7] == 1'b0) return "R4/R5";
      if (w == 8'h00 || w == 8'hFF)           return "R4/R5";
      if (w[0] && (w & 8'h7E) == 8'h00)       return "R3/R5";
      if ($countones(w) == 2)                 return "R2/R5";
      if ($countones(w) == 1)                 return "R1/R5";
      return "R4/R5";
   endfunction

   task automatic compare(input int i);
      logic [2:0] ep = ref_pos(hw[i]);
      n_chk++;
      if (pos_out !== ep) begin
         n_bad++;
         $display("FAIL %s word=%h pos actual=%0d expected=%0d",
                  req_of(hw[i]), hw[i], pos_out, ep);
      end
      if (pos_vld !== hv[i]) begin
         n_bad++;
         $display("FAIL R6 word=%h vld actual=%0b expected=%0b",
                  hw[i], pos_vld, hv[i]);
      end
   endtask

   // Drive at the falling edge; the result of the word driven three
   // falling edges back is visible now (capture edge + two cycles).
   task automatic apply(input logic [7:0] w, input logic v);
      @(negedge clk);
      if (n_idx >= 3) compare(n_idx - 3);
      hw[n_idx] = w;
      hv[n_idx] = v;
      word_in   = w;
      word_vld  = v;
      n_idx++;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #(5.0 * 20000);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] w;
      void'($urandom(32'h1f3a_5c07));

      // R7: reset state, including with a strobe and data applied
      word_vld = 1'b1;
      word_in  = 8'h80;
      repeat (4) @(negedge clk);
      n_chk++;
      if (pos_out !== 3'd0 || pos_vld !== 1'b0) begin
         n_bad++;
         $display("FAIL R7 during reset pos=%0d vld=%0b expected 0/0", pos_out, pos_vld);
      end
      word_vld = 1'b0;
      word_in  = 8'h00;
      rst      = 1'b0;
      @(negedge clk);
      n_chk++;
      if (pos_out !== 3'd0 || pos_vld !== 1'b0) begin
         n_bad++;
         $display("FAIL R7 after reset pos=%0d vld=%0b expected 0/0", pos_out, pos_vld);
      end

      // Directed corners: R1 ends, R2 neighbour, R3 wrap, R4 misfits
      apply(8'h80, 1'b1);  // R1 -> 0
      apply(8'h02, 1'b1);  // R1 -> 6
      apply(8'h01, 1'b1);  // R3 -> 7
      apply(8'hC0, 1'b1);  // R2 -> 0
      apply(8'h06, 1'b1);  // R2 -> 5
      apply(8'h81, 1'b1);  // R3 -> 7
      apply(8'h00, 1'b1);  // R4 -> 0
      apply(8'hFF, 1'b1);  // R4 -> 0
      apply(8'h41, 1'b0);  // R4 -> 0, R6 data decoded with valid low
      apply(8'h20, 1'b0);  // R6 -> 2 with valid low

      // R5 and R8: every word back to back, both lanes alternating
      for (int i = 0; i < 256; i++) apply(8'(i), 1'b1);

      // Random words, half shaped to match, random strobe (R6)
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(1, 0) == 1) begin
            int r = $urandom_range(7, 0);
            w = 8'h00;
            w[r] = 1'b1;
            w[(r == 0) ? 7 : r - 1] = 1'($urandom_range(1, 0));
         end else begin
            w = 8'($urandom());
         end
         apply(w, 1'($urandom_range(1, 0)));
      end

      // Flush the last three results out
      repeat (3) apply(8'h00, 1'b0);

      summary();
      $finish;
   end

endmodule